// File: doc/BRIEF.md
# Universal Shift Register with Shared Bidirectional Bus

The block is a parameterised universal register, eight stages wide by default. Two select inputs pick one of four synchronous operations on each rising clock edge: hold, shift toward the high stage, shift toward the low stage, or parallel load. Parallel data enters and leaves the register on the same set of bidirectional pins. Tri-state drivers put the register contents on those pins only when both active-low output enables are low and load is not selected. Selecting load releases the pins on its own, so an outside source can drive the word that the next edge captures.

The lowest and highest stages also appear on dedicated serial outputs that are always driven. Together with one serial input at each end, these outputs let several registers be chained into a longer word. The serial output of the highest stage feeds the low-end serial input of the next register up, and that register's lowest-stage output feeds back into the high-end serial input below. An active-low reset clears every stage at once. It does not wait for a clock edge and it overrides the selects.

Top module: `univ_shift_reg`

## Requirements
- R1: While rst_n is low, every stage reads 0. The clear takes effect as soon as rst_n falls, with no clock edge needed, and clock edges with any select value leave the register at 0 while rst_n stays low.
- R2: With {sel1,sel0} = 2'b00 (hold), a rising edge leaves every stage unchanged, whatever the serial inputs are.
- R3: With {sel1,sel0} = 2'b01 (shift right), a rising edge moves stage i into stage i+1 and loads ser_r_in into stage 0.
- R4: With {sel1,sel0} = 2'b10 (shift left), a rising edge moves stage i+1 into stage i and loads ser_l_in into stage WIDTH-1.
- R5: With {sel1,sel0} = 2'b11 (load), a rising edge copies bus_io bit i into stage i.
- R6: When oe0_n and oe1_n are both low and the selects are not 2'b11, bus_io bit i carries stage i.
- R7: When oe0_n is high, or oe1_n is high, or the selects are 2'b11, the block does not drive bus_io, so an external driver sets its value.
- R8: Hold, shifts, load and reset update the stages in the same way while bus_io is released.
- R9: q_first always carries stage 0 and q_last always carries stage WIDTH-1, independent of the output enables and the selects.
- R10: Two registers chained through their serial pins behave as one register of twice the width, in both shift directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| sel0 | input | 1 | Operation select, low bit |
| sel1 | input | 1 | Operation select, high bit |
| oe0_n | input | 1 | Output enable, active low |
| oe1_n | input | 1 | Output enable, active low |
| ser_r_in | input | 1 | Serial data entering stage 0 on a right shift |
| ser_l_in | input | 1 | Serial data entering stage WIDTH-1 on a left shift |
| bus_io | inout | WIDTH | Shared parallel bus: register output, or load data |
| q_first | output | 1 | Stage 0, always driven |
| q_last | output | 1 | Stage WIDTH-1, always driven |

## Verification
The bench builds two registers at the default WIDTH of 8 and chains them through their serial pins, so every shift is checked against a 16-bit model word. At this width every load value can be tried: all 256 words go into the lower register, with their complements in the upper one, and each is read back through the shared bus. Long shift runs in both directions, driven by arithmetic bit patterns, carry data across the boundary between the two registers. The bench also drives zero onto the bus under every combination that should release it, so a design that keeps driving shows up as a nonzero read.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;

    function automatic usr_mode_e mode_of(input logic s1, input logic s0);
        return usr_mode_e'({s1, s0});
    endfunction

endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
    import usr_pkg::*;
(
    input  logic      sel0,
    input  logic      sel1,
    input  logic      oe0_n,
    input  logic      oe1_n,
    output usr_mode_e mode,
    output logic      drive_en
);

    always_comb begin
        mode     = mode_of(sel1, sel0);
        drive_en = !oe0_n && !oe1_n && (mode != MODE_LOAD);
    end

endmodule

// File: rtl/usr_stage_mux.sv
module usr_stage_mux
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  usr_mode_e          mode,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   par_in,
    input  logic               ser_r,
    input  logic               ser_l,
    output logic [WIDTH-1:0]   nxt
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic from_low;
        logic from_high;

        if (i == 0) begin : g_low_end
            assign from_low = ser_r;
        end else begin : g_low_mid
            assign from_low = cur[i-1];
        end

        if (i == WIDTH - 1) begin : g_high_end
            assign from_high = ser_l;
        end else begin : g_high_mid
            assign from_high = cur[i+1];
        end

        always_comb begin
            unique case (mode)
                MODE_SHR:  nxt[i] = from_low;
                MODE_SHL:  nxt[i] = from_high;
                MODE_LOAD: nxt[i] = par_in[i];
                default:   nxt[i] = cur[i];
            endcase
        end
    end

endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel0,
    input  logic             sel1,
    input  logic             oe0_n,
    input  logic             oe1_n,
    input  logic             ser_r_in,
    input  logic             ser_l_in,
    inout  wire [WIDTH-1:0]  bus_io,
    output logic             q_first,
    output logic             q_last
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } reg_t;

    reg_t             r_d;
    reg_t             r_q;
    usr_mode_e        mode;
    logic             drive_en;
    logic [WIDTH-1:0] stage_nxt;
    logic [WIDTH-1:0] stage_q;

    usr_mode_dec i_dec (
        .sel0     (sel0),
        .sel1     (sel1),
        .oe0_n    (oe0_n),
        .oe1_n    (oe1_n),
        .mode     (mode),
        .drive_en (drive_en)
    );

    usr_stage_mux #(.WIDTH(WIDTH)) i_mux (
        .mode   (mode),
        .cur    (r_q.data),
        .par_in (bus_io),
        .ser_r  (ser_r_in),
        .ser_l  (ser_l_in),
        .nxt    (stage_nxt)
    );

    always_comb begin
        r_d      = r_q;
        r_d.data = stage_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign stage_q = r_q.data;
    assign bus_io  = drive_en ? stage_q : {WIDTH{1'bz}};
    assign q_first = stage_q[0];
    assign q_last  = stage_q[WIDTH-1];

endmodule

// File: rtl/usr_checker.sv
module usr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel0,
    input logic             sel1,
    input logic             oe0_n,
    input logic             oe1_n,
    input logic             ser_r_in,
    input logic             ser_l_in,
    input logic [WIDTH-1:0] bus_io,
    input logic             q_first,
    input logic             q_last,
    input logic [WIDTH-1:0] state
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> state == '0);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ({sel1, sel0} == 2'b00) |=> $stable(state));

    p_shift_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ({sel1, sel0} == 2'b01) |=> state == {$past(state[WIDTH-2:0]), $past(ser_r_in)});

    p_shift_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ({sel1, sel0} == 2'b10) |=> state == {$past(ser_l_in), $past(state[WIDTH-1:1])});

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({sel1, sel0} == 2'b11) |=> state == $past(bus_io));

    p_bus_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe0_n && !oe1_n && !(sel0 && sel1)) |-> bus_io == state);

    p_serial_taps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_first == state[0]) && (q_last == state[WIDTH-1]));

endmodule

bind univ_shift_reg usr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel0     (sel0),
    .sel1     (sel1),
    .oe0_n    (oe0_n),
    .oe1_n    (oe1_n),
    .ser_r_in (ser_r_in),
    .ser_l_in (ser_l_in),
    .bus_io   (bus_io),
    .q_first  (q_first),
    .q_last   (q_last),
    .state    (stage_q)
);

// File: tb/test_univ_shift_reg.sv
module test_univ_shift_reg;

    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n;
    logic         s0, s1, oe0_n, oe1_n, sr, sl;
    logic         tb_en;
    logic [W-1:0] tb_a, tb_b;
    wire  [W-1:0] bus_a, bus_b;
    logic         qf_a, ql_a, qf_b, ql_b;
    logic [2*W-1:0] w;
    int           total = 0;
    int           bad = 0;
    bit           done = 0;

    assign bus_a = tb_en ? tb_a : {W{1'bz}};
    assign bus_b = tb_en ? tb_b : {W{1'bz}};

    univ_shift_reg #(.WIDTH(W)) i_univ_shift_reg (
        .clk(clk), .rst_n(rst_n), .sel0(s0), .sel1(s1),
        .oe0_n(oe0_n), .oe1_n(oe1_n), .ser_r_in(sr), .ser_l_in(qf_b),
        .bus_io(bus_a), .q_first(qf_a), .q_last(ql_a)
    );

    univ_shift_reg #(.WIDTH(W)) i_univ_shift_reg_hi (
        .clk(clk), .rst_n(rst_n), .sel0(s0), .sel1(s1),
        .oe0_n(oe0_n), .oe1_n(oe1_n), .ser_r_in(ql_a), .ser_l_in(sl),
        .bus_io(bus_b), .q_first(qf_b), .q_last(ql_b)
    );

    task automatic chk(input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R9 taps"}, {12'd0, qf_b, ql_b, qf_a, ql_a}, {12'd0, w[W], w[2*W-1], w[0], w[W-1]});
        if (!oe0_n && !oe1_n && !(s0 && s1))
            chk({tag, " R6 bus"}, {bus_b, bus_a}, w);
    endtask

    task automatic cyc(input logic [1:0] m, input logic r, input logic l,
                       input logic [W-1:0] a, input logic [W-1:0] b);
        string tag;
        @(negedge clk);
        {s1, s0} = m; sr = r; sl = l;
        tb_en = (m == 2'b11); tb_a = a; tb_b = b;
        @(posedge clk);
        case (m)
            2'b01:   begin w = {w[2*W-2:0], r}; tag = "R3 R10 shift right"; end
            2'b10:   begin w = {l, w[2*W-1:1]}; tag = "R4 R10 shift left"; end
            2'b11:   begin w = {b, a};          tag = "R5 load"; end
            default: tag = "R2 hold";
        endcase
        #1;
        check_all(tag);
    endtask

    task automatic release_probe(input logic o0, input logic o1, input logic [1:0] m);
        @(negedge clk);
        oe0_n = o0; oe1_n = o1; {s1, s0} = m;
        tb_en = 1'b1; tb_a = '0; tb_b = '0;
        #1;
        chk("R7 bus released", {bus_b, bus_a}, '0);
        {s1, s0} = 2'b00; tb_en = 1'b0; oe0_n = 1'b0; oe1_n = 1'b0;
        #1;
        chk("R7 driven again", {bus_b, bus_a}, w);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; {s1, s0} = 2'b00; oe0_n = 1'b0; oe1_n = 1'b0;
        sr = 1'b0; sl = 1'b0; tb_en = 1'b0; tb_a = '0; tb_b = '0; w = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset state", {bus_b, bus_a}, '0);
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive load sweep with read back after a hold cycle.
        for (int v = 0; v < 256; v++) begin
            cyc(2'b11, 1'b0, 1'b0, W'(v), ~W'(v));
            cyc(2'b00, v[0], v[1], '0, '0);
        end

        // Shift runs across the chained boundary.
        cyc(2'b11, 1'b0, 1'b0, 8'h96, 8'h3C);
        for (int i = 0; i < 40; i++)
            cyc(2'b01, 1'(((i * 7) >> 2) & 1), 1'b1, '0, '0);
        for (int i = 0; i < 40; i++)
            cyc(2'b10, 1'b1, 1'(((i * 5 + 3) >> 1) & 1), '0, '0);
        for (int i = 0; i < 6; i++)
            cyc(2'b00, 1'(i), 1'(~i), '0, '0);

        // Explicit cascade: lower word moves into upper register.
        cyc(2'b11, 1'b0, 1'b0, 8'hC3, 8'h00);
        for (int i = 0; i < W; i++)
            cyc(2'b01, 1'b0, 1'b0, '0, '0);
        chk("R10 cascade right", {bus_b, bus_a}, {8'hC3, 8'h00});
        for (int i = 0; i < W; i++)
            cyc(2'b10, 1'b0, 1'b0, '0, '0);
        chk("R10 cascade left", {bus_b, bus_a}, {8'h00, 8'hC3});

        // Release conditions while state is nonzero.
        cyc(2'b11, 1'b0, 1'b0, 8'h5A, 8'hA5);
        cyc(2'b00, 1'b0, 1'b0, '0, '0);
        for (int m = 0; m < 4; m++) begin
            release_probe(1'b1, 1'b0, 2'(m));
            release_probe(1'b0, 1'b1, 2'(m));
            release_probe(1'b1, 1'b1, 2'(m));
        end
        release_probe(1'b0, 1'b0, 2'b11);

        // Internal operation while released.
        @(negedge clk);
        oe0_n = 1'b1;
        cyc(2'b01, 1'b1, 1'b0, '0, '0);
        cyc(2'b01, 1'b0, 1'b0, '0, '0);
        cyc(2'b10, 1'b0, 1'b1, '0, '0);
        cyc(2'b00, 1'b1, 1'b1, '0, '0);
        @(negedge clk);
        oe0_n = 1'b0; oe1_n = 1'b0;
        #1;
        chk("R8 shifted while released", {bus_b, bus_a}, w);
        @(negedge clk);
        oe1_n = 1'b1;
        cyc(2'b11, 1'b0, 1'b0, 8'h81, 8'h7E);
        cyc(2'b00, 1'b0, 1'b0, '0, '0);
        @(negedge clk);
        oe1_n = 1'b0;
        #1;
        chk("R8 loaded while released", {bus_b, bus_a}, {8'h7E, 8'h81});

        // Asynchronous reset between edges, then held against a load.
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        w = '0;
        chk("R1 async clear", {bus_b, bus_a}, '0);
        check_all("R1 async");
        {s1, s0} = 2'b11; tb_en = 1'b1; tb_a = 8'hFF; tb_b = 8'hFF;
        @(posedge clk);
        #1;
        {s1, s0} = 2'b00; tb_en = 1'b0;
        #1;
        chk("R1 override load", {bus_b, bus_a}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        oe0_n = 1'b1;
        #1;
        rst_n = 1'b0;
        #1;
        oe0_n = 1'b0;
        #1;
        chk("R8 R1 reset while released", {bus_b, bus_a}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(2'b01, 1'b1, 1'b0, '0, '0);

        done = 1;
        summary();
        $finish;
    end

endmodule